// File: doc/BRIEF.md
# Interleaved Result Multiplexer with Overrange

A time-interleaved converter runs eighteen successive-approximation slices side by side. Each slice samples the input in its own clock cycle and finishes its conversion some cycles later. This block merges the finished 13-bit slice words into a single output stream, one word per clock. A transfer index names the slice whose result is due in the current cycle. On the next rising edge the block registers that slice's word into the output.

The output word is a 12-bit straight-binary data field plus an overrange flag. A slice word above the 12-bit full-scale code is overrange: the flag goes high and all twelve data bits are forced high. An active-low output enable floats the data and overrange outputs. It does not disturb the registers behind them.

A valid strobe stays low after reset until the first sample has travelled through the 14-cycle pipeline. It then stays high. The transfer index is meant to advance by one slice per cycle. An index beyond the last slice is a non-transfer cycle and leaves the output unchanged.

Top module: `slice_merge`

## Requirements
- R1: While reset is held, the registered data field and overrange flag read zero and valid reads 0.
- R2: After a rising edge at which the transfer index is s (0 to 17) and slice s holds a code of 4095 or less, the data field equals that code and the overrange flag is 0.
- R3: The boundary codes 0 and 4095, and codes one step inside them, pass through unaltered with the overrange flag low.
- R4: A slice code of 4096 or more (bit 12 of the 13-bit word set) gives overrange flag 1 and data field 4095 (all twelve bits 1).
- R5: The outputs change only at a rising clock edge; input changes between edges do not reach them.
- R6: Valid is 0 for the first 14 rising edges after reset is released and becomes 1 at the 15th edge, so the sample taken at the first edge is presented exactly 14 edges later; valid then stays 1.
- R7: With the enable high, the data and overrange outputs are high-impedance. The registers keep updating, so the first edge-aligned sample after the enable returns low shows the current result.
- R8: The output enable has no effect on valid.
- R9: A rising edge at which the transfer index is 18 or more leaves the data field and overrange flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| slice_res | input | 234 | Eighteen 13-bit slice results; slice s occupies bits 13*s+12 down to 13*s |
| xfer_idx | input | 5 | Slice whose result transfers this cycle; 18 or more means no transfer |
| oe_n | input | 1 | Output enable, active low; high floats dout and ovr |
| dout | output | 12 | Straight-binary data field |
| ovr | output | 1 | Overrange flag |
| valid | output | 1 | High once the first sample has reached the output |

## Verification
Suppose the slice selection is wrong. The next output word, one edge after the faulty transfer cycle, then carries a neighbouring slice's code. The bench drives every non-transferring slice with a distinct code so that such a word cannot pass unnoticed. A wrong pipeline-fill count shows as valid rising one or more edges early or late. Broken saturation, a stuck enable, or a register that loads on a non-transfer cycle each show at the first edge where that case occurs.

// File: rtl/slice_merge.sv
module slice_merge #(
  parameter int SLICES = 18,
  parameter int RES_W  = 13,
  parameter int DATA_W = 12,
  parameter int LAT    = 14,
  localparam int IDX_W = $clog2(SLICES),
  localparam int CNT_W = $clog2(LAT + 1),
  localparam int FLAT  = SLICES * RES_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAT-1:0]   slice_res,
  input  logic [IDX_W-1:0]  xfer_idx,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              ovr,
  output logic              valid
);

  localparam logic [RES_W-1:0] FULL = {{(RES_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};

  logic [RES_W-1:0]  sel_w;
  logic              idx_ok;
  logic              over;
  logic [DATA_W-1:0] dq;
  logic              oq;
  logic              vq;
  logic [CNT_W-1:0]  fill;

  always_comb begin
    sel_w  = '0;
    idx_ok = 1'b0;
    for (int i = 0; i < SLICES; i++) begin
      if (xfer_idx == IDX_W'(i)) begin
        sel_w  = slice_res[i*RES_W +: RES_W];
        idx_ok = 1'b1;
      end
    end
  end

  assign over = sel_w > FULL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq   <= '0;
      oq   <= 1'b0;
      vq   <= 1'b0;
      fill <= '0;
    end else begin
      if (idx_ok) begin
        oq <= over;
        dq <= over ? {DATA_W{1'b1}} : sel_w[DATA_W-1:0];
      end
      if (fill != CNT_W'(LAT))
        fill <= fill + 1'b1;
      vq <= vq | (fill == CNT_W'(LAT));
    end
  end

  assign dout  = oe_n ? {DATA_W{1'bz}} : dq;
  assign ovr   = oe_n ? 1'bz : oq;
  assign valid = vq;

endmodule

// File: rtl/slice_merge_chk.sv
module slice_merge_chk #(
  parameter int SLICES = 18,
  parameter int RES_W  = 13,
  parameter int DATA_W = 12,
  parameter int LAT    = 14,
  localparam int IDX_W = $clog2(SLICES),
  localparam int FLAT  = SLICES * RES_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FLAT-1:0]   slice_res,
  input logic [IDX_W-1:0]  xfer_idx,
  input logic              valid,
  input logic [DATA_W-1:0] dq,
  input logic              oq
);

  int               ecnt;
  logic [RES_W-1:0] word;
  logic             w_over;
  logic             in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else if (ecnt <= LAT) ecnt <= ecnt + 1;
  end

  always_comb begin
    word     = '0;
    in_range = (int'(xfer_idx) < SLICES);
    if (in_range) word = RES_W'(slice_res >> (int'(xfer_idx) * RES_W));
    w_over   = (int'(word) >= (1 << DATA_W));
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (dq == '0 && !oq && !valid));

  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    oq |-> (&dq));

  a_r4_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_range |=> (oq == $past(w_over)));

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (in_range && !w_over) |=> (dq == $past(word[DATA_W-1:0])));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |=> ($stable(dq) && $stable(oq)));

  a_r6_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ecnt <= LAT) |-> !valid);

  a_r6_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
    (ecnt > LAT) |-> valid);

  a_r6_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);

endmodule

bind slice_merge slice_merge_chk #(
  .SLICES(SLICES), .RES_W(RES_W), .DATA_W(DATA_W), .LAT(LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slice_res(slice_res), .xfer_idx(xfer_idx),
  .valid(valid), .dq(dq), .oq(oq)
);

// File: tb/slice_merge_test.sv
`timescale 1ns/1ps
module slice_merge_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [233:0] slice_res = '0;
  logic [4:0]   xfer_idx = '0;
  logic         oe_n = 1'b0;
  wire  [11:0]  dout_w;
  wire          ovr_w;
  logic         valid;

  int checks = 0;
  int fails  = 0;
  int code [18];
  int samp_q [$];

  always #2.5 clk = ~clk;

  pullup (ovr_w);
  for (genvar g = 0; g < 12; g++) begin : g_pu
    pullup (dout_w[g]);
  end

  slice_merge uut (
    .clk(clk), .rst_n(rst_n), .slice_res(slice_res), .xfer_idx(xfer_idx),
    .oe_n(oe_n), .dout(dout_w), .ovr(ovr_w), .valid(valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fcode(input int k);
    case (k)
      1: return 0;
      2: return 4095;
      3: return 4096;
      4: return 8191;
      5: return 4094;
      6: return 1;
      default: return (k * 1237 + 91) % 8192;
    endcase
  endfunction

  task automatic pack();
    for (int s = 0; s < 18; s++) slice_res[s*13 +: 13] = 13'(code[s]);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int exp_d = 0;
    int exp_o = 0;
    for (int s = 0; s < 18; s++) code[s] = 4096 + s * 11;
    pack();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dout_w == 12'd0, "R1 data", int'(dout_w), 0);
    chk(ovr_w == 1'b0, "R1 ovr", int'(ovr_w), 0);
    chk(valid == 1'b0, "R1 valid", int'(valid), 0);
    rst_n = 1'b1;

    for (int n = 1; n <= 90; n++) begin
      int idx;
      int tgt;
      bit oob;
      bit have;
      string tag;
      samp_q.push_back(fcode(n));
      idx  = (n + 3) % 18;
      oob  = (n >= 60 && n <= 62);
      have = (n >= 15);
      tgt  = 0;
      if (have) tgt = samp_q.pop_front();
      for (int s = 0; s < 18; s++) code[s] = (s * 401 + n * 13 + 7) % 8192;
      if (have && !oob) code[idx] = tgt;
      xfer_idx = oob ? 5'(18 + (n - 60) * 4) : 5'(idx);
      oe_n = (n >= 40 && n <= 43);
      pack();
      #1;
      if (n > 1 && !oe_n) begin
        chk(dout_w == 12'(exp_d), "R5 data stable between edges", int'(dout_w), exp_d);
        chk(ovr_w == 1'(exp_o), "R5 ovr stable between edges", int'(ovr_w), exp_o);
      end
      @(posedge clk);
      if (!oob) begin
        exp_o = (code[idx] > 4095) ? 1 : 0;
        exp_d = exp_o ? 4095 : code[idx];
      end
      @(negedge clk);
      chk(valid == (n >= 15), oe_n ? "R8 valid under enable" : "R6 valid timing",
          int'(valid), int'(n >= 15));
      if (oe_n) begin
        chk(dout_w == 12'hfff, "R7 data floated", int'(dout_w), 4095);
        chk(ovr_w == 1'b1, "R7 ovr floated", int'(ovr_w), 1);
      end else begin
        if (oob)                  tag = "R9 hold";
        else if (n == 44)         tag = "R7 resume";
        else if (exp_o == 1)      tag = "R4 saturate";
        else if (n==15 || n==16 || n==19 || n==20) tag = "R3 boundary";
        else if (n == 29)         tag = "R6 latency";
        else                      tag = "R2 select";
        if (have && !oob && !oe_n)
          chk(int'(code[idx]) == tgt, "R6 sample order", code[idx], tgt);
        chk(dout_w == 12'(exp_d), tag, int'(dout_w), exp_d);
        chk(ovr_w == 1'(exp_o), tag, int'(ovr_w), exp_o);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule